// File: doc/BRIEF.md
# Low-Power Mode Clock Controller

This block decides which clocks of a two-domain processor run. One domain clocks the CPU core. The other, the system domain, clocks the peripherals and the interrupt logic. Software writes a 16-bit control word that holds a 2-bit sleep-depth field, a flag confirming that flash power is already off, and a set of per-peripheral clock enables. A single-cycle idle request then puts the block into the light, medium or deep sleep state that the field selects.

In each sleep state the block drops a fixed set of enables: core clock, system clock, watchdog clock, PLL and oscillator. It leaves a sleep state only on the wake events that the depth allows. After deep sleep it brings the clocks back in stages. The oscillator comes first. The PLL follows after a programmable settle time. The system domain follows after a second settle time, and the core domain comes back one cycle later. The gating cells and the analog parts sit outside the block and take these enable outputs.

Top module: `lpm_clk_ctrl`

## Requirements
- R1: After reset, core_clk_en, sys_clk_en, wd_clk_en, pll_en and osc_en are 1, periph_clk_en is all zero and halt_err is 0.
- R2: With cfg_wdata[13:12] = 00 latched, an idle_req in the running state clears core_clk_en one cycle later. The other four clock enables stay 1 (light sleep).
- R3: With field 01, an idle_req clears core_clk_en and sys_clk_en. wd_clk_en, pll_en and osc_en stay 1 (medium sleep).
- R4: With field 10 or 11 and the flash-off flag cfg_wdata[14] = 1, an idle_req clears all five clock enables (deep sleep).
- R5: With field 1x and flag 0, an idle_req leaves all clocks running. halt_err is then 1 for exactly one cycle.
- R6: Light sleep ends on periph_irq, ext_irq or fault_irq, and the core clock returns one cycle after the event is sampled. wake_irq alone does not end it.
- R7: Medium sleep ends on wake_irq, ext_irq or fault_irq. periph_irq alone does not end it. On exit, sys_clk_en returns one cycle before core_clk_en.
- R8: Deep sleep ends only on fault_irq. periph_irq, ext_irq and wake_irq leave every clock enable at 0.
- R9: On deep-sleep exit, osc_en and wd_clk_en rise one cycle after fault_irq is sampled. pll_en rises settle_len+1 cycles later, sys_clk_en rises a further settle_len+1 cycles later, and core_clk_en rises one cycle after that.
- R10: cfg_wdata[5:0], written with cfg_wr, drive periph_clk_en[5:0] bit for bit from the next cycle on. Without cfg_wr they hold.
- R11: idle_req has no effect outside the running state, including during the deep-sleep exit sequence.
- R12: The enables keep a fixed order at all times: core implies system, system implies PLL, PLL implies oscillator, and the watchdog clock equals the oscillator enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Write strobe for the control word |
| cfg_wdata | input | 16 | Control word: [14] flash off, [13:12] depth, [5:0] peripheral enables |
| idle_req | input | 1 | One-cycle request to enter the selected sleep depth |
| periph_irq | input | 1 | Any peripheral interrupt |
| ext_irq | input | 1 | External interrupt pin event |
| wake_irq | input | 1 | Dedicated wakeup interrupt |
| fault_irq | input | 1 | Power-stage protection interrupt |
| settle_len | input | 8 | Settle wait per deep-sleep exit stage, in cycles minus one |
| core_clk_en | output | 1 | CPU core clock enable |
| sys_clk_en | output | 1 | System domain clock enable |
| wd_clk_en | output | 1 | Watchdog clock enable |
| pll_en | output | 1 | PLL enable |
| osc_en | output | 1 | Oscillator enable |
| periph_clk_en | output | 6 | Per-peripheral clock enables |
| halt_err | output | 1 | One-cycle pulse: deep sleep refused, flash still powered |

## Verification
The hardest situation to reach is the staged deep-sleep exit, and in particular an idle_req that arrives halfway through it. To get there, the bench first has to program the flash-off flag and the depth field, enter deep sleep and wake it with a fault event. Only then can it pulse idle_req while the PLL settle count runs. It then counts cycles to each enable edge for two settle lengths. For every depth, the table-driven part pairs the depth with one event that must wake it and one that must not. Each vector therefore shows both the entry pattern and the effect of that event at the ports.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    typedef enum logic [2:0] {
        ST_RUN    = 3'd0,
        ST_LIGHT  = 3'd1,
        ST_MEDIUM = 3'd2,
        ST_DEEP   = 3'd3,
        ST_WK_OSC = 3'd4,
        ST_WK_PLL = 3'd5,
        ST_WK_SYS = 3'd6
    } lpm_state_e;

    typedef struct packed {
        logic core;
        logic sys;
        logic wd;
        logic pll;
        logic osc;
    } clk_en_t;

    // Enable pattern held in each state; outputs are registered from it.
    function automatic clk_en_t enables_for(lpm_state_e s);
        clk_en_t e;
        case (s)
            ST_RUN:    e = '{core: 1'b1, sys: 1'b1, wd: 1'b1, pll: 1'b1, osc: 1'b1};
            ST_LIGHT:  e = '{core: 1'b0, sys: 1'b1, wd: 1'b1, pll: 1'b1, osc: 1'b1};
            ST_MEDIUM: e = '{core: 1'b0, sys: 1'b0, wd: 1'b1, pll: 1'b1, osc: 1'b1};
            ST_DEEP:   e = '{core: 1'b0, sys: 1'b0, wd: 1'b0, pll: 1'b0, osc: 1'b0};
            ST_WK_OSC: e = '{core: 1'b0, sys: 1'b0, wd: 1'b1, pll: 1'b0, osc: 1'b1};
            ST_WK_PLL: e = '{core: 1'b0, sys: 1'b0, wd: 1'b1, pll: 1'b1, osc: 1'b1};
            ST_WK_SYS: e = '{core: 1'b0, sys: 1'b1, wd: 1'b1, pll: 1'b1, osc: 1'b1};
            default:   e = '{core: 1'b1, sys: 1'b1, wd: 1'b1, pll: 1'b1, osc: 1'b1};
        endcase
        return e;
    endfunction

endpackage

// File: rtl/lpm_cfg_reg.sv
module lpm_cfg_reg #(
    parameter int REG_W    = 16,
    parameter int NUM_PERI = 6,
    parameter int MODE_LSB = 12,
    parameter int FLASH_BIT = 14
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_wr,
    input  logic [REG_W-1:0]    cfg_wdata,
    output logic [1:0]          depth,
    output logic                flash_off,
    output logic [NUM_PERI-1:0] periph_en
);

    typedef struct packed {
        logic [1:0]          depth;
        logic                flash_off;
        logic [NUM_PERI-1:0] periph;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    // Bits of the word that carry no field in this block.
    logic unused_cfg_bits;
    assign unused_cfg_bits = ^cfg_wdata;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_wr) begin
            cfg_d.depth     = cfg_wdata[MODE_LSB +: 2];
            cfg_d.flash_off = cfg_wdata[FLASH_BIT];
            cfg_d.periph    = cfg_wdata[NUM_PERI-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign depth     = cfg_q.depth;
    assign flash_off = cfg_q.flash_off;
    assign periph_en = cfg_q.periph;

    assert_periph_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr |=> $stable(periph_en));

endmodule

// File: rtl/lpm_wake_qual.sv
module lpm_wake_qual
    import lpm_pkg::*;
(
    input  lpm_state_e state,
    input  logic       periph_irq,
    input  logic       ext_irq,
    input  logic       wake_irq,
    input  logic       fault_irq,
    output logic       wake
);

    // The deeper the sleep, the fewer sources still have a clock to reach us.
    always_comb begin
        case (state)
            ST_LIGHT:  wake = periph_irq | ext_irq | fault_irq;
            ST_MEDIUM: wake = wake_irq | ext_irq | fault_irq;
            ST_DEEP:   wake = fault_irq;
            default:   wake = 1'b0;
        endcase
    end

endmodule

// File: rtl/lpm_seq.sv
module lpm_seq
    import lpm_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             idle_req,
    input  logic [1:0]       depth,
    input  logic             flash_off,
    input  logic             wake,
    input  logic [CNT_W-1:0] settle_len,
    output lpm_state_e       state,
    output clk_en_t          en,
    output logic             halt_err
);

    typedef struct packed {
        lpm_state_e       st;
        logic [CNT_W-1:0] cnt;
        clk_en_t          en;
        logic             err;
    } seq_t;

    localparam seq_t SEQ_RESET = '{st: ST_RUN, cnt: '0, en: 5'b11111, err: 1'b0};

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d     = seq_q;
        seq_d.err = 1'b0;
        case (seq_q.st)
            ST_RUN: begin
                if (idle_req) begin
                    if (depth == 2'b00)      seq_d.st = ST_LIGHT;
                    else if (depth == 2'b01) seq_d.st = ST_MEDIUM;
                    else if (flash_off)      seq_d.st = ST_DEEP;
                    else                     seq_d.err = 1'b1;
                end
            end
            ST_LIGHT:  if (wake) seq_d.st = ST_RUN;
            ST_MEDIUM: if (wake) seq_d.st = ST_WK_SYS;
            ST_DEEP: begin
                if (wake) begin
                    seq_d.st  = ST_WK_OSC;
                    seq_d.cnt = settle_len;
                end
            end
            ST_WK_OSC: begin
                if (seq_q.cnt == '0) begin
                    seq_d.st  = ST_WK_PLL;
                    seq_d.cnt = settle_len;
                end else begin
                    seq_d.cnt = seq_q.cnt - CNT_W'(1);
                end
            end
            ST_WK_PLL: begin
                if (seq_q.cnt == '0) seq_d.st  = ST_WK_SYS;
                else                 seq_d.cnt = seq_q.cnt - CNT_W'(1);
            end
            ST_WK_SYS: seq_d.st = ST_RUN;
            default:   seq_d.st = ST_RUN;
        endcase
        // Enables follow the registered state only, so they cannot glitch.
        seq_d.en = enables_for(seq_d.st);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= SEQ_RESET;
        else        seq_q <= seq_d;
    end

    assign state    = seq_q.st;
    assign en       = seq_q.en;
    assign halt_err = seq_q.err;

    assert_core_needs_sys_R12: assert property (@(posedge clk) disable iff (!rst_n)
        en.core |-> en.sys);
    assert_sys_needs_pll_R12: assert property (@(posedge clk) disable iff (!rst_n)
        en.sys |-> en.pll);
    assert_pll_needs_osc_R12: assert property (@(posedge clk) disable iff (!rst_n)
        en.pll |-> (en.osc && en.wd == en.osc));
    assert_err_keeps_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
        halt_err |-> (en == 5'b11111));
    assert_core_after_sys_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en.core) |-> $past(en.sys));

endmodule

// File: rtl/lpm_clk_ctrl.sv
module lpm_clk_ctrl
    import lpm_pkg::*;
#(
    parameter int REG_W    = 16,
    parameter int NUM_PERI = 6,
    parameter int CNT_W    = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_wr,
    input  logic [REG_W-1:0]    cfg_wdata,
    input  logic                idle_req,
    input  logic                periph_irq,
    input  logic                ext_irq,
    input  logic                wake_irq,
    input  logic                fault_irq,
    input  logic [CNT_W-1:0]    settle_len,
    output logic                core_clk_en,
    output logic                sys_clk_en,
    output logic                wd_clk_en,
    output logic                pll_en,
    output logic                osc_en,
    output logic [NUM_PERI-1:0] periph_clk_en,
    output logic                halt_err
);

    localparam int MODE_LSB  = 12;
    localparam int FLASH_BIT = MODE_LSB + 2;

    logic [1:0] depth;
    logic       flash_off;
    logic       wake;
    lpm_state_e state;
    clk_en_t    en;

    lpm_cfg_reg #(
        .REG_W(REG_W), .NUM_PERI(NUM_PERI), .MODE_LSB(MODE_LSB), .FLASH_BIT(FLASH_BIT)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .depth(depth), .flash_off(flash_off), .periph_en(periph_clk_en)
    );

    lpm_wake_qual u_wake (
        .state(state), .periph_irq(periph_irq), .ext_irq(ext_irq),
        .wake_irq(wake_irq), .fault_irq(fault_irq), .wake(wake)
    );

    lpm_seq #(.CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .idle_req(idle_req), .depth(depth),
        .flash_off(flash_off), .wake(wake), .settle_len(settle_len),
        .state(state), .en(en), .halt_err(halt_err)
    );

    assign core_clk_en = en.core;
    assign sys_clk_en  = en.sys;
    assign wd_clk_en   = en.wd;
    assign pll_en      = en.pll;
    assign osc_en      = en.osc;

    assert_deep_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DEEP && !fault_irq) |=> (en == 5'b00000));
    assert_light_pattern_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LIGHT) |-> (sys_clk_en && !core_clk_en));
    assert_medium_pattern_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MEDIUM) |-> (!sys_clk_en && pll_en && osc_en));

endmodule

// File: tb/tb_lpm_clk_ctrl.sv
module tb_lpm_clk_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic        idle_req = 1'b0;
    logic        periph_irq = 1'b0, ext_irq = 1'b0, wake_irq = 1'b0, fault_irq = 1'b0;
    logic [7:0]  settle_len = 8'd2;
    logic        core_clk_en, sys_clk_en, wd_clk_en, pll_en, osc_en, halt_err;
    logic [5:0]  periph_clk_en;

    int n_chk = 0;
    int n_bad = 0;
    logic done = 1'b0;

    always #5 clk = ~clk;

    lpm_clk_ctrl dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .idle_req(idle_req), .periph_irq(periph_irq), .ext_irq(ext_irq),
        .wake_irq(wake_irq), .fault_irq(fault_irq), .settle_len(settle_len),
        .core_clk_en(core_clk_en), .sys_clk_en(sys_clk_en), .wd_clk_en(wd_clk_en),
        .pll_en(pll_en), .osc_en(osc_en), .periph_clk_en(periph_clk_en),
        .halt_err(halt_err)
    );

    // {core, sys, wd, pll, osc}
    function automatic logic [4:0] clks();
        return {core_clk_en, sys_clk_en, wd_clk_en, pll_en, osc_en};
    endfunction

    function automatic logic [4:0] entry_pattern(logic [1:0] m);
        if (m == 2'b00)      return 5'b01111;
        else if (m == 2'b01) return 5'b00111;
        else                 return 5'b00000;
    endfunction

    task automatic chk(string req, logic [15:0] got, logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic write_cfg(logic [1:0] m, logic fl, logic [5:0] p);
        @(negedge clk);
        cfg_wr = 1'b1;
        cfg_wdata = {1'b0, fl, m, 6'b0, p};
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic pulse_idle();
        @(negedge clk);
        idle_req = 1'b1;
        @(negedge clk);
        idle_req = 1'b0;
    endtask

    task automatic pulse_evt(logic [3:0] ev);
        @(negedge clk);
        {periph_irq, ext_irq, wake_irq, fault_irq} = ev;
        @(negedge clk);
        {periph_irq, ext_irq, wake_irq, fault_irq} = 4'b0;
    endtask

    task automatic wait_run(string req);
        logic ok = 1'b0;
        for (int i = 0; i < 80; i++) begin
            if (clks() == 5'b11111) begin
                ok = 1'b1;
                break;
            end
            @(negedge clk);
        end
        chk(req, {15'd0, ok}, 16'd1);
    endtask

    // [7:6] depth, [5] flash off, [4:1] {periph, ext, wake, fault}, [0] wakes
    localparam logic [7:0] VEC [12] = '{
        {2'b00, 1'b0, 4'b1000, 1'b1},
        {2'b00, 1'b0, 4'b0010, 1'b0},
        {2'b00, 1'b0, 4'b0100, 1'b1},
        {2'b00, 1'b0, 4'b0001, 1'b1},
        {2'b01, 1'b0, 4'b1000, 1'b0},
        {2'b01, 1'b0, 4'b0010, 1'b1},
        {2'b01, 1'b0, 4'b0100, 1'b1},
        {2'b01, 1'b0, 4'b0001, 1'b1},
        {2'b11, 1'b1, 4'b0100, 1'b0},
        {2'b10, 1'b1, 4'b1010, 1'b0},
        {2'b10, 1'b1, 4'b0001, 1'b1},
        {2'b11, 1'b1, 4'b0001, 1'b1}
    };

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 clocks", {11'd0, clks()}, 16'h001f);
        chk("R1 periph", {10'd0, periph_clk_en}, 16'h0000);
        chk("R1 err", {15'd0, halt_err}, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", {11'd0, clks()}, 16'h001f);

        // R10 peripheral enables
        write_cfg(2'b00, 1'b0, 6'h15);
        chk("R10 periph", {10'd0, periph_clk_en}, 16'h0015);
        repeat (3) @(negedge clk);
        chk("R10 hold", {10'd0, periph_clk_en}, 16'h0015);

        // Table: entry pattern, then one event that wakes or must not
        for (int v = 0; v < 12; v++) begin
            logic [1:0] m  = VEC[v][7:6];
            logic       fl = VEC[v][5];
            logic [3:0] ev = VEC[v][4:1];
            logic       wk = VEC[v][0];
            write_cfg(m, fl, 6'h2a);
            pulse_idle();
            chk(m == 2'b00 ? "R2 entry" : (m == 2'b01 ? "R3 entry" : "R4 entry"),
                {11'd0, clks()}, {11'd0, entry_pattern(m)});
            pulse_evt(ev);
            if (!wk) begin
                chk(m == 2'b00 ? "R6 no wake" : (m == 2'b01 ? "R7 no wake" : "R8 no wake"),
                    {11'd0, clks()}, {11'd0, entry_pattern(m)});
                pulse_evt(4'b0001);
            end else if (m == 2'b00) begin
                chk("R6 wake", {11'd0, clks()}, 16'h001f);
            end else if (m == 2'b01) begin
                chk("R7 sys first", {11'd0, clks()}, 16'h000f);
                @(negedge clk);
                chk("R7 core next", {11'd0, clks()}, 16'h001f);
            end else begin
                chk("R9 osc first", {11'd0, clks()}, 16'h0005);
            end
            wait_run("R8 return to run");
            chk("R10 periph kept", {10'd0, periph_clk_en}, 16'h002a);
        end

        // R5 deep sleep refused without flash-off flag
        write_cfg(2'b10, 1'b0, 6'h01);
        pulse_idle();
        chk("R5 err pulse", {15'd0, halt_err}, 16'h0001);
        chk("R5 clocks run", {11'd0, clks()}, 16'h001f);
        @(negedge clk);
        chk("R5 err one cycle", {15'd0, halt_err}, 16'h0000);

        // R9 exit timing with settle_len = 3
        settle_len = 8'd3;
        write_cfg(2'b11, 1'b1, 6'h01);
        pulse_idle();
        pulse_evt(4'b0001);
        chk("R9 osc+wd", {11'd0, clks()}, 16'h0005);
        // R11 idle_req during the wake sequence
        idle_req = 1'b1;
        repeat (3) @(negedge clk);
        idle_req = 1'b0;
        chk("R9 pll still off", {15'd0, pll_en}, 16'h0000);
        @(negedge clk);
        chk("R9 pll on", {11'd0, clks()}, 16'h0007);
        repeat (3) @(negedge clk);
        chk("R9 sys still off", {15'd0, sys_clk_en}, 16'h0000);
        @(negedge clk);
        chk("R9 sys on", {11'd0, clks()}, 16'h000f);
        @(negedge clk);
        chk("R11 run after wake", {11'd0, clks()}, 16'h001f);
        repeat (2) @(negedge clk);
        chk("R11 stays running", {11'd0, clks()}, 16'h001f);

        // R9 with settle_len = 0
        settle_len = 8'd0;
        pulse_idle();
        chk("R4 entry again", {11'd0, clks()}, 16'h0000);
        pulse_evt(4'b0001);
        chk("R9 s0 osc", {11'd0, clks()}, 16'h0005);
        @(negedge clk);
        chk("R9 s0 pll", {11'd0, clks()}, 16'h0007);
        @(negedge clk);
        chk("R9 s0 sys", {11'd0, clks()}, 16'h000f);
        @(negedge clk);
        chk("R12 s0 core last", {11'd0, clks()}, 16'h001f);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule